// File: doc/BRIEF.md
# Two-Level Carry Look-Ahead Adder

A purely combinational binary adder that adds two words and a carry-in. It produces a sum word and a carry-out. The word is split into equal groups of bits. Each group derives per-bit generate (both operand bits set) and propagate (exactly one operand bit set) terms. From these it computes every internal carry directly as a sum of products, with no rippling. Each group also reports a group generate and a group propagate.

A second-level look-ahead stage uses the same sum-of-products form on the group signals to compute the carry into every group and the final carry-out. No carry passes serially from one group to the next. The block also reports its own whole-word generate and propagate, so several copies can feed a further look-ahead level. The group width and the group count are parameters; the defaults give four groups of four bits.

Top module: `cla_adder16`

## Requirements
- R1: For every input, {c_out, sum_out} equals a_in + b_in + c_in, computed as an unsigned value one bit wider than the operands.
- R2: With a_in at zero and c_in at 0, sum_out equals b_in and c_out is 0.
- R3: grp_prop_out is 1 exactly when a_in XOR b_in has every bit set.
- R4: grp_gen_out is 1 exactly when a_in + b_in, taken without the carry-in, is at least 2 to the power of the word width.
- R5: c_out equals grp_gen_out OR (grp_prop_out AND c_in).
- R6: When a_in XOR b_in has every bit set, the carry-in travels the whole word: sum_out is all zeros with c_out at 1 when c_in is 1, and all ones with c_out at 0 when c_in is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | GRP_W*N_GRP (16) | First operand |
| b_in | input | GRP_W*N_GRP (16) | Second operand |
| c_in | input | 1 | Carry into the least significant bit |
| sum_out | output | GRP_W*N_GRP (16) | Sum word |
| c_out | output | 1 | Carry out of the most significant bit |
| grp_gen_out | output | 1 | Whole-word generate, for a further look-ahead level |
| grp_prop_out | output | 1 | Whole-word propagate, for a further look-ahead level |

## Verification
The bench builds the default shape of four 4-bit groups. A table of operand pairs targets full-propagate chains, carries generated at group boundaries and all-ones operands. Random pairs then add breadth. A second copy with two 3-bit groups gives a 6-bit adder with 13 input bits. It is swept over every input combination, so every carry path and every pattern of group generate and propagate is checked in a shape where exhaustive coverage is cheap. Using a group width that does not divide evenly into four also shows that the look-ahead terms scale with the parameters.

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int GRP_W = 4,
  parameter int N_GRP = 4,
  localparam int WIDTH = GRP_W * N_GRP
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             c_out,
  output logic             grp_gen_out,
  output logic             grp_prop_out
);

  localparam int MAXW = (GRP_W > N_GRP) ? GRP_W : N_GRP;

  // Carry out of the low n positions, formed as one flat sum of products.
  function automatic logic la_carry(input logic [MAXW-1:0] gv,
                                    input logic [MAXW-1:0] pv,
                                    input logic cin, input int n);
    logic acc, term;
    acc = 1'b0;
    for (int j = 0; j < MAXW; j++) begin
      if (j < n) begin
        term = gv[j];
        for (int m = 0; m < MAXW; m++)
          if (m > j && m < n) term = term & pv[m];
        acc = acc | term;
      end
    end
    term = cin;
    for (int m = 0; m < MAXW; m++)
      if (m < n) term = term & pv[m];
    return acc | term;
  endfunction

  logic [WIDTH-1:0] bit_p, bit_g, bit_c;
  logic [N_GRP-1:0] grp_g, grp_p;
  logic [N_GRP:0]   grp_c;

  assign bit_p = a_in ^ b_in;
  assign bit_g = a_in & b_in;

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    logic [MAXW-1:0] gl, pl;
    assign gl = MAXW'(bit_g[k*GRP_W +: GRP_W]);
    assign pl = MAXW'(bit_p[k*GRP_W +: GRP_W]);
    assign grp_g[k] = la_carry(gl, pl, 1'b0, GRP_W);
    assign grp_p[k] = &bit_p[k*GRP_W +: GRP_W];
    for (genvar i = 0; i < GRP_W; i++) begin : g_bit
      assign bit_c[k*GRP_W + i] = la_carry(gl, pl, grp_c[k], i);
    end
  end

  logic [MAXW-1:0] gg_x, gp_x;
  assign gg_x = MAXW'(grp_g);
  assign gp_x = MAXW'(grp_p);

  assign grp_c[0] = c_in;
  for (genvar k = 1; k <= N_GRP; k++) begin : g_top
    assign grp_c[k] = la_carry(gg_x, gp_x, c_in, k);
  end

  assign sum_out      = bit_p ^ bit_c;
  assign c_out        = grp_c[N_GRP];
  assign grp_gen_out  = la_carry(gg_x, gp_x, 1'b0, N_GRP);
  assign grp_prop_out = &grp_p;

endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int GRP_W = 4,
  parameter int N_GRP = 4,
  localparam int WIDTH = GRP_W * N_GRP
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             c_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             c_out,
  input logic             grp_gen_out,
  input logic             grp_prop_out
);

  logic [WIDTH:0] full_sum, raw_sum;
  assign full_sum = (WIDTH+1)'(a_in) + (WIDTH+1)'(b_in) + (WIDTH+1)'(c_in);
  assign raw_sum  = (WIDTH+1)'(a_in) + (WIDTH+1)'(b_in);

  always_comb begin
    a_r1_sum: assert ({c_out, sum_out} == full_sum)
      else $error("R1 sum mismatch");
    a_r3_prop: assert (grp_prop_out == (&(a_in ^ b_in)))
      else $error("R3 propagate mismatch");
    a_r4_gen: assert (grp_gen_out == raw_sum[WIDTH])
      else $error("R4 generate mismatch");
    a_r5_cout: assert (c_out == (grp_gen_out | (grp_prop_out & c_in)))
      else $error("R5 carry-out mismatch");
    if (&(a_in ^ b_in)) begin
      a_r6_chain: assert (sum_out == {WIDTH{~c_in}} && c_out == c_in)
        else $error("R6 propagate chain mismatch");
    end
  end

endmodule

bind cla_adder16 cla_adder16_chk #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_chk (
  .a_in(a_in), .b_in(b_in), .c_in(c_in), .sum_out(sum_out), .c_out(c_out),
  .grp_gen_out(grp_gen_out), .grp_prop_out(grp_prop_out)
);

// File: tb/tb_cla_adder16.sv
`timescale 1ns/1ps
module tb_cla_adder16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] a, b, s;
  logic        ci, co, gg, gp;
  logic [5:0]  na, nb, ns;
  logic        nci, nco, ngg, ngp;

  cla_adder16 dut (.a_in(a), .b_in(b), .c_in(ci), .sum_out(s), .c_out(co),
                   .grp_gen_out(gg), .grp_prop_out(gp));

  cla_adder16 #(.GRP_W(3), .N_GRP(2)) dut_narrow (
    .a_in(na), .b_in(nb), .c_in(nci), .sum_out(ns), .c_out(nco),
    .grp_gen_out(ngg), .grp_prop_out(ngp));

  // {a, b, c_in, expected {carry, sum}}
  localparam logic [49:0] VEC [12] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h00000},
    {16'hFFFF, 16'h0001, 1'b0, 17'h10000},
    {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
    {16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},
    {16'hAAAA, 16'h5555, 1'b1, 17'h10000},
    {16'h00FF, 16'h0001, 1'b0, 17'h00100},
    {16'h1234, 16'h4321, 1'b0, 17'h05555},
    {16'h8000, 16'h8000, 1'b0, 17'h10000},
    {16'h0FFF, 16'hF000, 1'b1, 17'h10000},
    {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
    {16'h7FFF, 16'h0001, 1'b0, 17'h08000},
    {16'h000F, 16'h0001, 1'b0, 17'h00010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] av, input logic [15:0] bv, input logic cv);
    a = av; b = bv; ci = cv;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [16:0] full, raw;
    full = {1'b0, a} + {1'b0, b} + {16'b0, ci};
    raw  = {1'b0, a} + {1'b0, b};
    chk({tag, " R1 sum"}, {15'b0, co, s}, {15'b0, full});
    chk({tag, " R3 prop"}, {31'b0, gp}, {31'b0, &(a ^ b)});
    chk({tag, " R4 gen"}, {31'b0, gg}, {31'b0, raw[16]});
    chk({tag, " R5 cout"}, {31'b0, co}, {31'b0, gg | (gp & ci)});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    na = '0; nb = '0; nci = 1'b0;
    repeat (3) @(negedge clk);
    // reset state: zero inputs give zero outputs (R2)
    chk("R2 reset sum", {15'b0, co, s}, 32'h0);
    chk("R4 reset gen", {31'b0, gg}, 32'h0);
    rst_n = 1'b1;

    // R1 table walk
    for (int i = 0; i < 12; i++) begin
      drive(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
      chk("R1 table", {15'b0, co, s}, {15'b0, VEC[i][16:0]});
      check_all("table");
    end

    // R2: zero operand passes the other through
    drive(16'h0000, 16'hBEEF, 1'b0);
    chk("R2 pass-through sum", {16'b0, s}, 32'h0000BEEF);
    chk("R2 pass-through carry", {31'b0, co}, 32'h0);

    // R6: full propagate chains
    drive(16'hF0F0, 16'h0F0F, 1'b1);
    chk("R6 chain cin=1 sum", {16'b0, s}, 32'h0);
    chk("R6 chain cin=1 carry", {31'b0, co}, 32'h1);
    chk("R3 chain prop", {31'b0, gp}, 32'h1);
    drive(16'h1357, 16'hECA8, 1'b0);
    chk("R6 chain cin=0 sum", {16'b0, s}, 32'h0000FFFF);
    chk("R6 chain cin=0 carry", {31'b0, co}, 32'h0);

    // R4: generate in the top group only, carry-in irrelevant
    drive(16'hF000, 16'h1000, 1'b0);
    chk("R4 top-group gen", {31'b0, gg}, 32'h1);
    chk("R3 top-group prop", {31'b0, gp}, 32'h0);

    // R5 / R1 random
    for (int i = 0; i < 2000; i++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom));
      check_all("random");
    end

    // exhaustive narrow shape (R1, R3, R4, R5)
    for (int v = 0; v < 8192; v++) begin
      logic [6:0] full, raw;
      na = v[12:7]; nb = v[6:1]; nci = v[0];
      #1;
      full = {1'b0, na} + {1'b0, nb} + {6'b0, nci};
      raw  = {1'b0, na} + {1'b0, nb};
      chk("R1 narrow sum", {25'b0, nco, ns}, {25'b0, full});
      chk("R3 narrow prop", {31'b0, ngp}, {31'b0, &(na ^ nb)});
      chk("R4 narrow gen", {31'b0, ngg}, {31'b0, raw[6]});
      chk("R5 narrow cout", {31'b0, nco}, {31'b0, ngg | (ngp & nci)});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule